// File: doc/BRIEF.md
# USB Host Channel Packet Sequencer

This block runs one host channel's transfer as a series of packets. Software first loads a configuration: the endpoint kind, the direction, the largest packet size the endpoint takes, how many packets the transfer may contain and the total byte count. It then writes the control port to start the channel. The block then gives a downstream transaction engine one packet request at a time, each with a byte size. It waits for each packet to finish before it issues the next one.

For transfers toward the device (OUT), every packet is full-sized except the last, which carries whatever bytes are left over. A transfer of one packet carries exactly the programmed byte count, so a count of zero sends an empty packet. For transfers from the device (IN), the total is only an upper bound. A packet shorter than the maximum ends the transfer early. The transfer also ends when the packet count reaches zero.

Software can abort the channel by writing enable and disable together. If a packet is already with the engine, the channel stops once that packet finishes. The block then sets a halted flag. Completion and halt each have a flag, and each flag has its own interrupt mask.

Top module: `usbh_chan_seq`

## Requirements
- R1: After reset, ch_en, ch_dis, req_valid, flag_cmpl, flag_halt and irq are 0, and pkt_left and bytes_left are 0.
- R2: A control write with ctl_en=1 and ctl_dis=0 while the channel is idle loads pkt_left and bytes_left from the configuration. At the same edge it raises ch_en and req_valid. While req_valid is high, req_dir_in and req_ep_kind equal the configured direction and the 2-bit endpoint kind.
- R3: For an OUT transfer with a packet count of 1, the single request has req_size equal to the total length. A total length of 0 gives a single request of size 0.
- R4: For an OUT transfer with a packet count above 1, every request has req_size equal to the maximum packet length, except the one made when pkt_left is 1, which requests the bytes still left.
- R5: Each packet completion (done_valid while a packet is in flight) lowers pkt_left by 1. It lowers bytes_left by req_size for OUT or by done_len for IN, and bytes_left never goes below 0.
- R6: Every IN request asks for the maximum packet length. An IN completion with done_len below the maximum packet length ends the transfer, even if packets remain.
- R7: At the edge that takes the final completion, ch_en falls and flag_cmpl rises.
- R8: A start with a configured packet count of 0 issues no request. At that same edge it sets flag_cmpl, and ch_en stays 0.
- R9: Configuration writes made while ch_en or ch_dis is high are ignored. The running transfer and the next transfer both use the earlier values.
- R10: An abort write (ctl_en=1, ctl_dis=1) while a request is still unaccepted drops req_valid and ch_en at that edge and sets flag_halt. flag_cmpl is not set.
- R11: An abort write while a packet is in flight sets ch_dis and keeps ch_en high until that packet completes. At the completion, ch_en and ch_dis fall and flag_halt sets. No further request follows, and flag_cmpl is not set even if that packet was the last one.
- R12: irq is high exactly when (flag_cmpl and the completion mask) or (flag_halt and the halt mask) is true. A mask write takes effect at its own edge. A clear write with clr_we=1 removes each flag whose clear bit is 1, and a flag being set at the same edge wins over the clear.
- R13: Once raised, req_valid stays high with an unchanged req_size until req_ready is seen, unless an abort write arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_max_pkt | input | MPS_W | Maximum packet length in bytes |
| cfg_pkt_cnt | input | PCNT_W | Packet count of the transfer |
| cfg_xfer_len | input | LEN_W | Total transfer length in bytes (upper bound for IN) |
| cfg_dir_in | input | 1 | 1 for IN, 0 for OUT |
| cfg_ep_kind | input | 2 | Endpoint kind: 0 control, 1 isochronous, 2 bulk, 3 interrupt |
| ctl_we | input | 1 | Control write strobe |
| ctl_en | input | 1 | Enable bit of the control write |
| ctl_dis | input | 1 | Disable bit of the control write |
| ie_we | input | 1 | Interrupt mask write strobe |
| ie_cmpl | input | 1 | Completion interrupt mask |
| ie_halt | input | 1 | Halt interrupt mask |
| clr_we | input | 1 | Flag clear strobe |
| clr_cmpl | input | 1 | Clear the completion flag |
| clr_halt | input | 1 | Clear the halted flag |
| req_valid | output | 1 | Packet request to the engine |
| req_ready | input | 1 | Engine accepts the request |
| req_size | output | LEN_W | Bytes in the requested packet |
| req_dir_in | output | 1 | Direction of the request |
| req_ep_kind | output | 2 | Endpoint kind of the request |
| done_valid | input | 1 | The in-flight packet has finished |
| done_len | input | MPS_W | Bytes received (IN only) |
| ch_en | output | 1 | Channel enable state |
| ch_dis | output | 1 | Abort pending on an in-flight packet |
| pkt_left | output | PCNT_W | Packets remaining |
| bytes_left | output | LEN_W | Bytes remaining |
| flag_cmpl | output | 1 | Transfer complete flag |
| flag_halt | output | 1 | Channel halted flag |
| irq | output | 1 | Masked interrupt |

## Verification
Two events can hit the same edge: an abort write and the completion of the channel's final packet. The engine model in the bench provokes this by driving the abort write on the same cycle as done_valid for a one-packet transfer. The result is judged by flag_halt being set while flag_cmpl stays clear, with the counters still advanced to zero. A second collision happens when the engine accepts a request on the same edge as an abort write. That packet then counts as in flight, so the halt waits for its completion.

// File: rtl/usbh_chan_pkg.sv
`timescale 1ns/1ps
package usbh_chan_pkg;

  // Endpoint kind carried with each request (2-bit code).
  typedef enum logic [1:0] {
    EP_CTRL = 2'd0,
    EP_ISO  = 2'd1,
    EP_BULK = 2'd2,
    EP_INTR = 2'd3
  } ep_kind_e;

  // Sequencer states.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } chan_state_e;

endpackage

// File: rtl/usbh_chan_cfg.sv
`timescale 1ns/1ps
module usbh_chan_cfg
  import usbh_chan_pkg::*;
#(
  parameter int MPS_W  = 11,
  parameter int PCNT_W = 10,
  parameter int LEN_W  = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              cfg_we,
  input  logic [MPS_W-1:0]  cfg_max_pkt,
  input  logic [PCNT_W-1:0] cfg_pkt_cnt,
  input  logic [LEN_W-1:0]  cfg_xfer_len,
  input  logic              cfg_dir_in,
  input  logic [1:0]        cfg_ep_kind,
  output logic [MPS_W-1:0]  max_pkt_q,
  output logic [PCNT_W-1:0] pkt_cnt_q,
  output logic [LEN_W-1:0]  xfer_len_q,
  output logic              dir_in_q,
  output ep_kind_e          ep_kind_q
);

  // Fields are writable only while enable and disable are both clear.
  logic accept;
  assign accept = cfg_we && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      max_pkt_q  <= '0;
      pkt_cnt_q  <= '0;
      xfer_len_q <= '0;
      dir_in_q   <= 1'b0;
      ep_kind_q  <= EP_CTRL;
    end else if (accept) begin
      max_pkt_q  <= cfg_max_pkt;
      pkt_cnt_q  <= cfg_pkt_cnt;
      xfer_len_q <= cfg_xfer_len;
      dir_in_q   <= cfg_dir_in;
      ep_kind_q  <= ep_kind_e'(cfg_ep_kind);
    end
  end

endmodule

// File: rtl/usbh_chan_ctr.sv
`timescale 1ns/1ps
module usbh_chan_ctr #(
  parameter int MPS_W  = 11,
  parameter int PCNT_W = 10,
  parameter int LEN_W  = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              take,
  input  logic [MPS_W-1:0]  max_pkt,
  input  logic [PCNT_W-1:0] pkt_init,
  input  logic [LEN_W-1:0]  len_init,
  input  logic              dir_in,
  input  logic [MPS_W-1:0]  rx_len,
  output logic [PCNT_W-1:0] pkt_left,
  output logic [LEN_W-1:0]  bytes_left,
  output logic [LEN_W-1:0]  pkt_size,
  output logic              final_pkt,
  output logic              short_pkt
);

  localparam logic [PCNT_W-1:0] ONE_PKT = PCNT_W'(1);

  logic [LEN_W-1:0]  max_w;
  logic [LEN_W-1:0]  rx_w;
  logic [LEN_W-1:0]  used;
  logic [LEN_W-1:0]  bytes_nx;
  logic [PCNT_W-1:0] pkt_nx;

  always_comb begin
    max_w = LEN_W'(max_pkt);
    rx_w  = LEN_W'(rx_len);
    // IN asks for a full packet; OUT sends full packets until the last one,
    // which carries whatever bytes are still owed.
    if (dir_in)
      pkt_size = max_w;
    else if (pkt_left == ONE_PKT)
      pkt_size = bytes_left;
    else
      pkt_size = max_w;
    used      = dir_in ? rx_w : pkt_size;
    bytes_nx  = (used >= bytes_left) ? '0 : (bytes_left - used);
    pkt_nx    = (pkt_left == '0) ? '0 : (pkt_left - ONE_PKT);
    final_pkt = (pkt_nx == '0);
    short_pkt = dir_in && (rx_len < max_pkt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_left   <= '0;
      bytes_left <= '0;
    end else if (load) begin
      pkt_left   <= pkt_init;
      bytes_left <= len_init;
    end else if (take) begin
      pkt_left   <= pkt_nx;
      bytes_left <= bytes_nx;
    end
  end

endmodule

// File: rtl/usbh_chan_fsm.sv
`timescale 1ns/1ps
module usbh_chan_fsm
  import usbh_chan_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic abort_req,
  input  logic empty_xfer,
  input  logic req_ready,
  input  logic done_valid,
  input  logic final_pkt,
  input  logic short_pkt,
  output logic ch_en,
  output logic ch_dis,
  output logic req_valid,
  output logic load,
  output logic take,
  output logic set_cmpl,
  output logic set_halt
);

  chan_state_e st_q, st_d;
  logic        en_q, en_d;
  logic        dis_q, dis_d;
  logic        vld_q, vld_d;

  always_comb begin
    st_d     = st_q;
    en_d     = en_q;
    dis_d    = dis_q;
    vld_d    = vld_q;
    load     = 1'b0;
    take     = 1'b0;
    set_cmpl = 1'b0;
    set_halt = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_req) begin
          load = 1'b1;
          if (empty_xfer) begin
            set_cmpl = 1'b1;
          end else begin
            st_d  = ST_ISSUE;
            en_d  = 1'b1;
            vld_d = 1'b1;
          end
        end
      end
      ST_ISSUE: begin
        if (req_ready) begin
          // Accepted packet is in flight even if an abort lands now.
          st_d  = ST_WAIT;
          vld_d = 1'b0;
          if (abort_req) dis_d = 1'b1;
        end else if (abort_req) begin
          st_d     = ST_IDLE;
          en_d     = 1'b0;
          vld_d    = 1'b0;
          set_halt = 1'b1;
        end
      end
      ST_WAIT: begin
        if (abort_req) dis_d = 1'b1;
        if (done_valid) begin
          take = 1'b1;
          if (dis_q || abort_req) begin
            // Abort has priority over completion.
            st_d     = ST_IDLE;
            en_d     = 1'b0;
            dis_d    = 1'b0;
            set_halt = 1'b1;
          end else if (final_pkt || short_pkt) begin
            st_d     = ST_IDLE;
            en_d     = 1'b0;
            set_cmpl = 1'b1;
          end else begin
            st_d  = ST_ISSUE;
            vld_d = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      en_q  <= 1'b0;
      dis_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      en_q  <= en_d;
      dis_q <= dis_d;
      vld_q <= vld_d;
    end
  end

  assign ch_en     = en_q;
  assign ch_dis    = dis_q;
  assign req_valid = vld_q;

endmodule

// File: rtl/usbh_chan_irq.sv
`timescale 1ns/1ps
module usbh_chan_irq (
  input  logic clk,
  input  logic rst,
  input  logic ie_we,
  input  logic ie_cmpl,
  input  logic ie_halt,
  input  logic clr_we,
  input  logic clr_cmpl,
  input  logic clr_halt,
  input  logic set_cmpl,
  input  logic set_halt,
  output logic flag_cmpl,
  output logic flag_halt,
  output logic irq
);

  logic cmpl_d, halt_d, iec_q, iec_d, ieh_q, ieh_d;

  always_comb begin
    cmpl_d = set_cmpl || (flag_cmpl && !(clr_we && clr_cmpl));
    halt_d = set_halt || (flag_halt && !(clr_we && clr_halt));
    iec_d  = ie_we ? ie_cmpl : iec_q;
    ieh_d  = ie_we ? ie_halt : ieh_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_cmpl <= 1'b0;
      flag_halt <= 1'b0;
      iec_q     <= 1'b0;
      ieh_q     <= 1'b0;
      irq       <= 1'b0;
    end else begin
      flag_cmpl <= cmpl_d;
      flag_halt <= halt_d;
      iec_q     <= iec_d;
      ieh_q     <= ieh_d;
      irq       <= (cmpl_d && iec_d) || (halt_d && ieh_d);
    end
  end

endmodule

// File: rtl/usbh_chan_seq.sv
`timescale 1ns/1ps
module usbh_chan_seq
  import usbh_chan_pkg::*;
#(
  parameter int MPS_W  = 11,
  parameter int PCNT_W = 10,
  parameter int LEN_W  = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [MPS_W-1:0]  cfg_max_pkt,
  input  logic [PCNT_W-1:0] cfg_pkt_cnt,
  input  logic [LEN_W-1:0]  cfg_xfer_len,
  input  logic              cfg_dir_in,
  input  logic [1:0]        cfg_ep_kind,
  input  logic              ctl_we,
  input  logic              ctl_en,
  input  logic              ctl_dis,
  input  logic              ie_we,
  input  logic              ie_cmpl,
  input  logic              ie_halt,
  input  logic              clr_we,
  input  logic              clr_cmpl,
  input  logic              clr_halt,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [LEN_W-1:0]  req_size,
  output logic              req_dir_in,
  output logic [1:0]        req_ep_kind,
  input  logic              done_valid,
  input  logic [MPS_W-1:0]  done_len,
  output logic              ch_en,
  output logic              ch_dis,
  output logic [PCNT_W-1:0] pkt_left,
  output logic [LEN_W-1:0]  bytes_left,
  output logic              flag_cmpl,
  output logic              flag_halt,
  output logic              irq
);

  logic [MPS_W-1:0]  max_pkt_q;
  logic [PCNT_W-1:0] pkt_cnt_q;
  logic [LEN_W-1:0]  xfer_len_q;
  logic              dir_in_q;
  ep_kind_e          ep_kind_q;

  logic start_req, abort_req, load, take, set_cmpl, set_halt;
  logic final_pkt, short_pkt;

  assign start_req = ctl_we && ctl_en && !ctl_dis;
  assign abort_req = ctl_we && ctl_en && ctl_dis;

  usbh_chan_cfg #(.MPS_W(MPS_W), .PCNT_W(PCNT_W), .LEN_W(LEN_W)) u_cfg (
    .clk          (clk),
    .rst          (rst),
    .busy         (ch_en || ch_dis),
    .cfg_we       (cfg_we),
    .cfg_max_pkt  (cfg_max_pkt),
    .cfg_pkt_cnt  (cfg_pkt_cnt),
    .cfg_xfer_len (cfg_xfer_len),
    .cfg_dir_in   (cfg_dir_in),
    .cfg_ep_kind  (cfg_ep_kind),
    .max_pkt_q    (max_pkt_q),
    .pkt_cnt_q    (pkt_cnt_q),
    .xfer_len_q   (xfer_len_q),
    .dir_in_q     (dir_in_q),
    .ep_kind_q    (ep_kind_q)
  );

  usbh_chan_ctr #(.MPS_W(MPS_W), .PCNT_W(PCNT_W), .LEN_W(LEN_W)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .take       (take),
    .max_pkt    (max_pkt_q),
    .pkt_init   (pkt_cnt_q),
    .len_init   (xfer_len_q),
    .dir_in     (dir_in_q),
    .rx_len     (done_len),
    .pkt_left   (pkt_left),
    .bytes_left (bytes_left),
    .pkt_size   (req_size),
    .final_pkt  (final_pkt),
    .short_pkt  (short_pkt)
  );

  usbh_chan_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start_req  (start_req),
    .abort_req  (abort_req),
    .empty_xfer (pkt_cnt_q == '0),
    .req_ready  (req_ready),
    .done_valid (done_valid),
    .final_pkt  (final_pkt),
    .short_pkt  (short_pkt),
    .ch_en      (ch_en),
    .ch_dis     (ch_dis),
    .req_valid  (req_valid),
    .load       (load),
    .take       (take),
    .set_cmpl   (set_cmpl),
    .set_halt   (set_halt)
  );

  usbh_chan_irq u_irq (
    .clk       (clk),
    .rst       (rst),
    .ie_we     (ie_we),
    .ie_cmpl   (ie_cmpl),
    .ie_halt   (ie_halt),
    .clr_we    (clr_we),
    .clr_cmpl  (clr_cmpl),
    .clr_halt  (clr_halt),
    .set_cmpl  (set_cmpl),
    .set_halt  (set_halt),
    .flag_cmpl (flag_cmpl),
    .flag_halt (flag_halt),
    .irq       (irq)
  );

  assign req_dir_in  = dir_in_q;
  assign req_ep_kind = ep_kind_q;

endmodule

// File: rtl/usbh_chan_chk.sv
`timescale 1ns/1ps
module usbh_chan_chk #(
  parameter int MPS_W  = 11,
  parameter int PCNT_W = 10,
  parameter int LEN_W  = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic              ctl_we,
  input logic              ctl_en,
  input logic              ctl_dis,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LEN_W-1:0]  req_size,
  input logic              done_valid,
  input logic              ch_en,
  input logic              ch_dis,
  input logic [PCNT_W-1:0] pkt_left,
  input logic              flag_cmpl,
  input logic              flag_halt,
  input logic              irq
);

  localparam logic [PCNT_W-1:0] UNIT = PCNT_W'(1);

  assert_req_implies_en_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ch_en);

  assert_cfg_locked_R9: assert property (@(posedge clk) disable iff (rst)
    (ch_en && cfg_we && !done_valid) |=> $stable(req_size));

  assert_pkt_step_R5: assert property (@(posedge clk) disable iff (rst)
    (ch_en && !req_valid && done_valid) |=> (pkt_left == $past(pkt_left) - UNIT));

  assert_halt_drops_en_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_halt) |-> (!ch_en && !req_valid));

  assert_dis_within_en_R11: assert property (@(posedge clk) disable iff (rst)
    ch_dis |-> (ch_en && !req_valid));

  assert_irq_needs_flag_R12: assert property (@(posedge clk) disable iff (rst)
    (!flag_cmpl && !flag_halt) |-> !irq);

  assert_req_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !(ctl_we && ctl_en && ctl_dis)) |=>
      (req_valid && $stable(req_size)));

endmodule

bind usbh_chan_seq usbh_chan_chk #(
  .MPS_W(MPS_W), .PCNT_W(PCNT_W), .LEN_W(LEN_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_we     (cfg_we),
  .ctl_we     (ctl_we),
  .ctl_en     (ctl_en),
  .ctl_dis    (ctl_dis),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_size   (req_size),
  .done_valid (done_valid),
  .ch_en      (ch_en),
  .ch_dis     (ch_dis),
  .pkt_left   (pkt_left),
  .flag_cmpl  (flag_cmpl),
  .flag_halt  (flag_halt),
  .irq        (irq)
);

// File: tb/tb_usbh_chan_seq.sv
`timescale 1ns/1ps
module tb_usbh_chan_seq;
  localparam int MPS_W = 11, PCNT_W = 10, LEN_W = 19;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst;
  logic cfg_we, cfg_dir_in;
  logic [MPS_W-1:0] cfg_max_pkt;
  logic [PCNT_W-1:0] cfg_pkt_cnt;
  logic [LEN_W-1:0] cfg_xfer_len;
  logic [1:0] cfg_ep_kind;
  logic drv_we, drv_en, drv_dis, eng_ab;
  logic ctl_we, ctl_en, ctl_dis;
  logic ie_we, ie_cmpl, ie_halt, clr_we, clr_cmpl, clr_halt;
  logic req_valid, req_ready, req_dir_in;
  logic [LEN_W-1:0] req_size;
  logic [1:0] req_ep_kind;
  logic done_valid;
  logic [MPS_W-1:0] done_len;
  logic ch_en, ch_dis, flag_cmpl, flag_halt, irq;
  logic [PCNT_W-1:0] pkt_left;
  logic [LEN_W-1:0] bytes_left;

  assign ctl_we  = drv_we  | eng_ab;
  assign ctl_en  = drv_en  | eng_ab;
  assign ctl_dis = drv_dis | eng_ab;

  usbh_chan_seq #(.MPS_W(MPS_W), .PCNT_W(PCNT_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_max_pkt(cfg_max_pkt),
    .cfg_pkt_cnt(cfg_pkt_cnt), .cfg_xfer_len(cfg_xfer_len), .cfg_dir_in(cfg_dir_in),
    .cfg_ep_kind(cfg_ep_kind), .ctl_we(ctl_we), .ctl_en(ctl_en), .ctl_dis(ctl_dis),
    .ie_we(ie_we), .ie_cmpl(ie_cmpl), .ie_halt(ie_halt), .clr_we(clr_we),
    .clr_cmpl(clr_cmpl), .clr_halt(clr_halt), .req_valid(req_valid),
    .req_ready(req_ready), .req_size(req_size), .req_dir_in(req_dir_in),
    .req_ep_kind(req_ep_kind), .done_valid(done_valid), .done_len(done_len),
    .ch_en(ch_en), .ch_dis(ch_dis), .pkt_left(pkt_left), .bytes_left(bytes_left),
    .flag_cmpl(flag_cmpl), .flag_halt(flag_halt), .irq(irq)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int exp_q[$];
  int rx_q[$];
  bit eng_hold = 1'b0;
  bit eng_abort_at_done = 1'b0;
  int eng_lat = 1;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Engine model and scoreboard monitor: pops the expected size of each request.
  initial begin
    req_ready = 1'b0; done_valid = 1'b0; done_len = '0; eng_ab = 1'b0;
    forever begin
      @(negedge clk);
      if (req_valid && !eng_hold) begin
        if (exp_q.size() == 0) begin
          chk("R2", "unexpected request size", req_size, -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(req_dir_in ? "R6" : "R4", "request size", req_size, e);
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        repeat (eng_lat) @(negedge clk);
        done_valid = 1'b1;
        done_len = (req_dir_in && rx_q.size() > 0) ? MPS_W'(rx_q.pop_front()) : '0;
        if (eng_abort_at_done) eng_ab = 1'b1;
        @(negedge clk);
        done_valid = 1'b0;
        eng_ab = 1'b0;
      end
    end
  end

  task automatic cfg(input int pc, input int len, input int mps, input bit din, input int kind);
    @(negedge clk);
    cfg_we = 1'b1; cfg_pkt_cnt = PCNT_W'(pc); cfg_xfer_len = LEN_W'(len);
    cfg_max_pkt = MPS_W'(mps); cfg_dir_in = din; cfg_ep_kind = 2'(kind);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ctl(input bit en, input bit dis);
    @(negedge clk);
    drv_we = 1'b1; drv_en = en; drv_dis = dis;
    @(negedge clk);
    drv_we = 1'b0; drv_en = 1'b0; drv_dis = 1'b0;
  endtask

  task automatic set_ie(input bit c, input bit h);
    @(negedge clk);
    ie_we = 1'b1; ie_cmpl = c; ie_halt = h;
    @(negedge clk);
    ie_we = 1'b0;
  endtask

  task automatic clr(input bit c, input bit h);
    @(negedge clk);
    clr_we = 1'b1; clr_cmpl = c; clr_halt = h;
    @(negedge clk);
    clr_we = 1'b0;
  endtask

  task automatic wait_idle();
    while (ch_en) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 0; cfg_dir_in = 0; cfg_max_pkt = '0; cfg_pkt_cnt = '0;
    cfg_xfer_len = '0; cfg_ep_kind = '0; drv_we = 0; drv_en = 0; drv_dis = 0;
    ie_we = 0; ie_cmpl = 0; ie_halt = 0; clr_we = 0; clr_cmpl = 0; clr_halt = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "ch_en", ch_en, 0);
    chk("R1", "req_valid", req_valid, 0);
    chk("R1", "flags", {flag_cmpl, flag_halt, ch_dis}, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "pkt_left", pkt_left, 0);
    set_ie(1, 1);

    // R2 R4: OUT 3 packets, 150 bytes, max 64 -> 64,64,22
    cfg(3, 150, 64, 0, 2);
    exp_q.push_back(64); exp_q.push_back(64); exp_q.push_back(22);
    ctl(1, 0);
    chk("R2", "ch_en after start", ch_en, 1);
    chk("R2", "req_valid after start", req_valid, 1);
    chk("R2", "req_dir_in", req_dir_in, 0);
    chk("R2", "req_ep_kind", req_ep_kind, 2);
    wait_idle();
    chk("R7", "flag_cmpl", flag_cmpl, 1);
    chk("R5", "pkt_left", pkt_left, 0);
    chk("R5", "bytes_left", bytes_left, 0);
    chk("R12", "irq on completion", irq, 1);
    chk("R4", "all requests seen", exp_q.size(), 0);
    clr(1, 1);
    chk("R12", "flag cleared", flag_cmpl, 0);

    // R3: single packet of 40, then zero-length
    cfg(1, 40, 64, 0, 2);
    exp_q.push_back(40);
    ctl(1, 0); wait_idle();
    chk("R3", "single packet done", flag_cmpl, 1);
    chk("R3", "requests seen", exp_q.size(), 0);
    clr(1, 1);
    cfg(1, 0, 64, 0, 0);
    exp_q.push_back(0);
    ctl(1, 0); wait_idle();
    chk("R3", "zero-length done", flag_cmpl, 1);
    chk("R3", "zero-length seen", exp_q.size(), 0);
    clr(1, 1);

    // R6: IN short packet ends early
    cfg(4, 256, 64, 1, 3);
    exp_q.push_back(64); exp_q.push_back(64);
    rx_q.push_back(64); rx_q.push_back(20);
    ctl(1, 0);
    chk("R2", "req_dir_in IN", req_dir_in, 1);
    chk("R2", "req_ep_kind IN", req_ep_kind, 3);
    wait_idle();
    chk("R6", "short completes", flag_cmpl, 1);
    chk("R6", "pkt_left after short", pkt_left, 2);
    chk("R5", "bytes_left after short", bytes_left, 172);
    clr(1, 1);

    // R6 R5: IN count reaches zero, byte floor at zero
    cfg(2, 30, 64, 1, 2);
    exp_q.push_back(64); exp_q.push_back(64);
    rx_q.push_back(64); rx_q.push_back(64);
    ctl(1, 0); wait_idle();
    chk("R6", "count zero completes", flag_cmpl, 1);
    chk("R5", "bytes floor", bytes_left, 0);
    chk("R6", "pkt_left", pkt_left, 0);
    clr(1, 1);

    // R9: config write during transfer ignored, also for next transfer
    eng_lat = 5;
    cfg(2, 100, 64, 0, 2);
    exp_q.push_back(64); exp_q.push_back(36);
    ctl(1, 0);
    cfg(3, 500, 8, 0, 1);
    chk("R9", "ep kind unchanged", req_ep_kind, 2);
    wait_idle();
    clr(1, 1);
    exp_q.push_back(64); exp_q.push_back(36);
    ctl(1, 0); wait_idle();
    chk("R9", "old config reused", exp_q.size(), 0);
    chk("R9", "bytes_left", bytes_left, 0);
    clr(1, 1);
    eng_lat = 1;

    // R8: zero packet count
    cfg(0, 0, 64, 0, 2);
    ctl(1, 0);
    chk("R8", "ch_en stays low", ch_en, 0);
    chk("R8", "flag_cmpl", flag_cmpl, 1);
    repeat (4) @(negedge clk);
    chk("R8", "no request", req_valid, 0);
    clr(1, 1);

    // R10 R13: abort before acceptance
    eng_hold = 1'b1;
    cfg(2, 128, 64, 0, 2);
    ctl(1, 0);
    repeat (3) @(negedge clk);
    chk("R13", "req held", req_valid, 1);
    chk("R13", "size held", req_size, 64);
    ctl(1, 1);
    chk("R10", "req_valid dropped", req_valid, 0);
    chk("R10", "ch_en dropped", ch_en, 0);
    chk("R10", "flag_halt", flag_halt, 1);
    chk("R10", "flag_cmpl", flag_cmpl, 0);
    chk("R10", "pkt_left", pkt_left, 2);
    eng_hold = 1'b0;
    clr(1, 1);

    // R11: abort while a packet is in flight
    eng_lat = 12;
    cfg(3, 192, 64, 0, 2);
    exp_q.push_back(64);
    ctl(1, 0);
    while (req_valid) @(negedge clk);
    ctl(1, 1);
    chk("R11", "ch_dis pending", ch_dis, 1);
    chk("R11", "ch_en held", ch_en, 1);
    wait_idle();
    chk("R11", "flag_halt", flag_halt, 1);
    chk("R11", "flag_cmpl", flag_cmpl, 0);
    chk("R11", "ch_dis cleared", ch_dis, 0);
    chk("R11", "pkt_left", pkt_left, 2);
    chk("R11", "bytes_left", bytes_left, 128);
    repeat (5) @(negedge clk);
    chk("R11", "no further request", req_valid, 0);
    clr(1, 1);

    // R11: abort on the same cycle as the final completion
    eng_lat = 3; eng_abort_at_done = 1'b1;
    cfg(1, 10, 64, 0, 2);
    exp_q.push_back(10);
    ctl(1, 0); wait_idle();
    eng_abort_at_done = 1'b0;
    chk("R11", "coincident halt", flag_halt, 1);
    chk("R11", "coincident no cmpl", flag_cmpl, 0);
    chk("R5", "coincident pkt_left", pkt_left, 0);
    chk("R11", "coincident ch_dis", ch_dis, 0);
    clr(1, 1);

    // R12: masking and clear
    set_ie(0, 1);
    cfg(1, 5, 64, 0, 2);
    exp_q.push_back(5);
    ctl(1, 0); wait_idle();
    chk("R12", "flag set while masked", flag_cmpl, 1);
    chk("R12", "irq masked", irq, 0);
    set_ie(1, 1);
    chk("R12", "irq after unmask", irq, 1);
    clr(1, 0);
    chk("R12", "irq after clear", irq, 0);
    chk("R12", "flag after clear", flag_cmpl, 0);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule